// File: doc/BRIEF.md
# Dual-Protocol Test Stimulus Serializer

This block produces serial test traffic for a bus monitor. It takes 32-bit words from the read port of a first-word-fall-through FIFO. It sends each word as 33 bit periods: the 32 stored bits, least significant first, and then one extra bit that is always high. Because every word has the same 33-bit shape, a single shifter can generate traffic for two different serial protocols.

A mode input picks how the three output lines (clock, data and sync) behave.

- **Byte-frame mode:** the host packs three 11-bit byte frames into each word. The serial clock runs all the time, and the extra bit becomes the stop bit of the third frame.
- **Burst mode:** the block sends 32 clock pulses with data for each word. The sync line then goes high for the 33rd bit period, and no clock pulse occurs during that period.

Both modes are timed by one free-running bit timer, and each bit period lasts a set number of system clock cycles. Each output line changes on the serial clock edge opposite to the edge the receiver samples on.

Top module: `stim_serializer`

## Requirements
- R1: While rstN is low, serClk is 0, serData is 1, serSync is 0 and fifoRd is 0.
- R2: Each FIFO word occupies exactly 33 bit periods of 2*HALF_CYC system cycles. Words that are already waiting in the FIFO follow each other with no gap, so in burst mode the sync pulses of consecutive words start 66*HALF_CYC cycles apart.
- R3: With modeSel = 0 (byte-frame mode), serClk toggles every HALF_CYC cycles without stopping, including while the FIFO is empty.
- R4: In byte-frame mode, word bits [10:0], [21:11] and {1, [31:22]} go out in that order as three frames. Each frame is bit 0 = start (0), bits 8:1 = data byte LSB first, bit 9 = odd parity over the data, bit 10 = stop (1). The stop bit of the third frame is the always-high 33rd bit. A receiver samples on the rising edge of serClk.
- R5: In byte-frame mode, serData changes only in a cycle where serClk falls.
- R6: In byte-frame mode, serData stays 1 while no word is being sent.
- R7: With modeSel = 1 (burst mode), each word produces exactly 32 falling edges of serClk. The data sampled at those edges is the word, LSB first.
- R8: In burst mode, outside the sync period and the cycle right after it, serData changes only in a cycle where serClk rises.
- R9: In burst mode, serSync is high for exactly one bit period (2*HALF_CYC cycles) per word, serClk is low throughout it, and serSync is never high in byte-frame mode.
- R10: fifoRd is a one-cycle pulse, one per word, asserted only while fifoEmpty is 0. fifoData is taken in the same cycle as that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | 0 = byte-frame mode, 1 = burst mode |
| fifoEmpty | input | 1 | FIFO has no word available |
| fifoData | input | WORD_W | Head word of the FIFO, valid while fifoEmpty is 0 |
| fifoRd | output | 1 | Pops the head word of the FIFO |
| serClk | output | 1 | Serial clock line |
| serData | output | 1 | Serial data line |
| serSync | output | 1 | End-of-word sync line (burst mode) |

## Verification
The assertions assume that modeSel changes only while the block is idle, and never during a word or a sync period. They also assume that fifoData is stable and valid whenever fifoEmpty is low. The stimulus keeps to both assumptions in three ways:

- The bench models the FIFO, and that model only pops on fifoRd.
- The bench changes the mode only after the FIFO has drained and the last word, including its sync period, has finished.
- The bench's own receiver ignores the few cycles after a mode change, while the serial clock re-aligns to the new mode.

// File: rtl/stim_ser_pkg.sv
package stim_ser_pkg;

  typedef enum logic {
    MODE_BYTE  = 1'b0,
    MODE_BURST = 1'b1
  } serModeE;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic load;     // take a new word from the FIFO head
    logic shift;    // advance to the next bit of the word
    logic active;   // a word is in flight
    logic lastBit;  // current bit is the always-high extra bit
    logic phase;    // 0 = first half of bit period, 1 = second half
  } ctlStrobeT;

endpackage

// File: rtl/stim_ser_ctrl.sv
module stim_ser_ctrl
  import stim_ser_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int HALF_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fifoEmpty,
  output logic      fifoRd,
  output ctlStrobeT strobe
);

  localparam int BIT_CNT = WORD_W + 1;
  localparam int IDX_W   = $clog2(BIT_CNT + 1);
  localparam int HC_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [HC_W-1:0]  halfCnt;
  logic             phase;
  logic             active;
  logic [IDX_W-1:0] bitIdx;

  logic halfTick;
  logic bitEnd;
  logic lastBit;
  logic doShift;

  assign halfTick = (halfCnt == HC_W'(HALF_CYC - 1));
  assign bitEnd   = halfTick & phase;
  assign lastBit  = (bitIdx == IDX_W'(WORD_W));
  assign fifoRd   = bitEnd & (~active | lastBit) & ~fifoEmpty;
  assign doShift  = bitEnd & active & ~lastBit;

  // free-running half-bit timer; keeps the byte-mode clock alive when idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      phase   <= 1'b0;
    end else begin
      halfCnt <= halfTick ? '0 : halfCnt + 1'b1;
      if (halfTick) phase <= ~phase;
    end
  end

  // word sequencing across the 33 bit periods
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bitIdx <= '0;
    end else if (fifoRd) begin
      active <= 1'b1;
      bitIdx <= '0;
    end else if (doShift) begin
      bitIdx <= bitIdx + 1'b1;
    end else if (bitEnd && active && lastBit) begin
      active <= 1'b0;
    end
  end

  always_comb begin
    strobe.load    = fifoRd;
    strobe.shift   = doShift;
    strobe.active  = active;
    strobe.lastBit = lastBit;
    strobe.phase   = phase;
  end

endmodule

// File: rtl/stim_ser_dpath.sv
module stim_ser_dpath
  import stim_ser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  serModeE           modeSel,
  input  logic [WORD_W-1:0] fifoData,
  input  ctlStrobeT         strobe,
  output logic              serClk,
  output logic              serData,
  output logic              serSync
);

  localparam int SH_W = WORD_W + 1;

  logic [SH_W-1:0] shReg;
  logic            clkNext;
  logic            dataNext;
  logic            syncNext;

  // extra always-high bit rides at the top of the shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '1;
    end else if (strobe.load) begin
      shReg <= {1'b1, fifoData};
    end else if (strobe.shift) begin
      shReg <= {1'b1, shReg[SH_W-1:1]};
    end
  end

  always_comb begin
    if (modeSel == MODE_BYTE) begin
      // low in first half: data moves on the fall, receiver samples on the rise
      clkNext  = strobe.phase;
      syncNext = 1'b0;
    end else begin
      // high in first half: data moves on the rise, receiver samples on the fall
      clkNext  = strobe.active & ~strobe.lastBit & ~strobe.phase;
      syncNext = strobe.active & strobe.lastBit;
    end
    dataNext = strobe.active ? shReg[0] : 1'b1;
  end

  // registered lines so all three move in the same cycle without glitches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      serClk  <= 1'b0;
      serData <= 1'b1;
      serSync <= 1'b0;
    end else begin
      serClk  <= clkNext;
      serData <= dataNext;
      serSync <= syncNext;
    end
  end

endmodule

// File: rtl/stim_serializer.sv
module stim_serializer
  import stim_ser_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              fifoEmpty,
  input  logic [WORD_W-1:0] fifoData,
  output logic              fifoRd,
  output logic              serClk,
  output logic              serData,
  output logic              serSync
);

  ctlStrobeT strobe;
  serModeE   modeQ;

  assign modeQ = serModeE'(modeSel);

  stim_ser_ctrl #(
    .WORD_W  (WORD_W),
    .HALF_CYC(HALF_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fifoEmpty(fifoEmpty),
    .fifoRd   (fifoRd),
    .strobe   (strobe)
  );

  stim_ser_dpath #(
    .WORD_W(WORD_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeQ),
    .fifoData(fifoData),
    .strobe  (strobe),
    .serClk  (serClk),
    .serData (serData),
    .serSync (serSync)
  );

endmodule

// File: rtl/stim_ser_chk.sv
module stim_ser_chk (
  input logic clk,
  input logic rstN,
  input logic modeSel,
  input logic fifoEmpty,
  input logic fifoRd,
  input logic serClk,
  input logic serData,
  input logic serSync
);

  // R10
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> !fifoEmpty);

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> !fifoRd);

  // R9
  sync_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    serSync |-> !serClk);

  // R9
  sync_burst_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    serSync |-> modeSel);

  // R5
  byte_data_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && $stable(modeSel) && (serData != $past(serData))) |-> $fell(serClk));

  // R8
  burst_data_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && $stable(modeSel) && (serData != $past(serData))
      && !serSync && !$past(serSync)) |-> $rose(serClk));

endmodule

bind stim_serializer stim_ser_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modeSel  (modeSel),
  .fifoEmpty(fifoEmpty),
  .fifoRd   (fifoRd),
  .serClk   (serClk),
  .serData  (serData),
  .serSync  (serSync)
);

// File: tb/sim_stim_serializer.sv
module sim_stim_serializer;

  localparam int HALF    = 2;
  localparam int BIT_CYC = 2 * HALF;
  localparam int WORD_CYC = 33 * BIT_CYC;

  // {mode, payload}: mode 0 uses payload[23:0] as three bytes, mode 1 the full word
  localparam logic [32:0] VEC [0:7] = '{
    {1'b0, 32'h00A5FF00},
    {1'b0, 32'h007E813C},
    {1'b0, 32'h00558001},
    {1'b1, 32'h00000001},
    {1'b1, 32'hFFFFFFFF},
    {1'b1, 32'h80000000},
    {1'b1, 32'hDEADBEEF},
    {1'b0, 32'h00C30F6D}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSel = 1'b0;
  logic        fifoEmpty;
  logic [31:0] fifoData;
  logic        fifoRd;
  logic        serClk;
  logic        serData;
  logic        serSync;

  always #2 clk = ~clk;

  stim_serializer #(.WORD_W(32), .HALF_CYC(HALF)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .fifoEmpty(fifoEmpty),
    .fifoData(fifoData), .fifoRd(fifoRd), .serClk(serClk),
    .serData(serData), .serSync(serSync)
  );

  // FIFO model
  logic [31:0] fmem [0:15];
  logic [4:0]  wrPtr = '0;
  logic [4:0]  rdPtr = '0;
  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoData  = fmem[rdPtr[3:0]];
  always @(posedge clk) if (fifoRd) rdPtr <= rdPtr + 1'b1;

  int checks = 0;
  int fails  = 0;
  int pushes = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fmem[wrPtr[3:0]] = w;
    wrPtr = wrPtr + 1'b1;
    pushes++;
  endtask

  function automatic logic [10:0] frm(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction

  function automatic logic [31:0] packWord(input logic [23:0] p);
    logic [10:0] f2;
    f2 = frm(p[23:16]);
    return {f2[9:0], frm(p[15:8]), frm(p[7:0])};
  endfunction

  // receiving monitor
  int cyc = 0;
  logic prevClk = 1'b0, prevData = 1'b1, prevSync = 1'b0, prevMode = 1'b0;
  int modeAge = 0;
  logic rxBusy = 1'b0;
  int rxCnt = 0;
  logic [10:0] rxSh = '0;
  int nFrames = 0;
  logic [10:0] frames [0:63];
  logic [31:0] acc = '0;
  int fallCnt = 0;
  int nWords = 0;
  logic [31:0] words [0:63];
  int wordFalls [0:63];
  int syncRise [0:63];
  int syncRun = 0;
  int lastSyncW = 0;
  int rdPulses = 0;
  int r5Bad = 0, r8Bad = 0, r9Bad = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (fifoRd) rdPulses++;
      if (modeSel != prevMode) modeAge = 0;
      else if (modeAge < 8) modeAge++;
      if (modeAge >= 4) begin
        if (!modeSel) begin
          if ((serData != prevData) && !(prevClk && !serClk)) r5Bad++;
          if (serClk && !prevClk) begin
            if (!rxBusy && !serData) begin
              rxBusy = 1'b1; rxSh = '0; rxCnt = 1;
            end else if (rxBusy) begin
              rxSh[rxCnt] = serData;
              rxCnt++;
              if (rxCnt == 11) begin
                frames[nFrames[5:0]] = rxSh;
                nFrames++;
                rxBusy = 1'b0;
              end
            end
          end
        end else begin
          if ((serData != prevData) && !serSync && !prevSync && !(!prevClk && serClk)) r8Bad++;
          if (serSync && serClk) r9Bad++;
          if (!serClk && prevClk) begin
            acc = {serData, acc[31:1]};
            fallCnt++;
          end
          if (serSync && !prevSync) begin
            words[nWords[5:0]] = acc;
            wordFalls[nWords[5:0]] = fallCnt;
            syncRise[nWords[5:0]] = cyc;
            nWords++;
            fallCnt = 0;
          end
        end
      end else begin
        fallCnt = 0;
        rxBusy = 1'b0;
      end
      if (serSync) syncRun++;
      else if (prevSync) begin lastSyncW = syncRun; syncRun = 0; end
    end
    prevClk = serClk; prevData = serData; prevSync = serSync; prevMode = modeSel;
  end

  task automatic setMode(input logic m);
    modeSel = m;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (5) @(negedge clk);
    check(serClk == 1'b0, "R1 serClk in reset", serClk, 0);
    check(serData == 1'b1, "R1 serData in reset", serData, 1);
    check(serSync == 1'b0, "R1 serSync in reset", serSync, 0);
    check(fifoRd == 1'b0, "R1 fifoRd in reset", fifoRd, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R3 and R6: idle byte mode, clock alive and data high
    begin
      int rises = 0;
      int highs = 0;
      logic pc;
      pc = serClk;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (serClk && !pc) rises++;
        if (serData) highs++;
        pc = serClk;
      end
      check(rises == 40 / BIT_CYC, "R3 idle clock rises", rises, 40 / BIT_CYC);
      check(highs == 40, "R6 idle data high", highs, 40);
    end

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic m;
      logic [31:0] p;
      m = VEC[i][32];
      p = VEC[i][31:0];
      if (modeSel != m) setMode(m);
      if (!m) begin
        int base;
        base = nFrames;
        push(packWord(p[23:0]));
        for (int t = 0; t < 3 * WORD_CYC && nFrames < base + 3; t++) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
          logic [10:0] ex;
          ex = frm(p[8*k +: 8]);
          check(frames[(base + k) % 64] == ex, "R4 byte frame", frames[(base + k) % 64], ex);
        end
      end else begin
        int base;
        base = nWords;
        push(p);
        for (int t = 0; t < 3 * WORD_CYC && nWords < base + 1; t++) @(negedge clk);
        check(words[base % 64] == p, "R7 burst word LSB first", words[base % 64], p);
        check(wordFalls[base % 64] == 32, "R7 clock falls per word", wordFalls[base % 64], 32);
      end
      repeat (20) @(negedge clk);
    end

    // R2 and R9: three burst words back to back
    setMode(1'b1);
    begin
      int base;
      base = nWords;
      push(32'hFF000011); push(32'h0F0F0F0F); push(32'hFF0000AA);
      for (int t = 0; t < 6 * WORD_CYC && nWords < base + 3; t++) @(negedge clk);
      repeat (3 * BIT_CYC) @(negedge clk);
      check(syncRise[(base + 1) % 64] - syncRise[base % 64] == WORD_CYC, "R2 word spacing",
            syncRise[(base + 1) % 64] - syncRise[base % 64], WORD_CYC);
      check(syncRise[(base + 2) % 64] - syncRise[(base + 1) % 64] == WORD_CYC, "R2 word spacing",
            syncRise[(base + 2) % 64] - syncRise[(base + 1) % 64], WORD_CYC);
      check(words[(base + 1) % 64] == 32'h0F0F0F0F, "R7 back-to-back word",
            words[(base + 1) % 64], 32'h0F0F0F0F);
      check(lastSyncW == BIT_CYC, "R9 sync width", lastSyncW, BIT_CYC);
    end

    // R5 byte-mode stream back to back after returning
    setMode(1'b0);
    begin
      int base;
      base = nFrames;
      push(packWord(24'h112233)); push(packWord(24'hFE0180));
      for (int t = 0; t < 6 * WORD_CYC && nFrames < base + 6; t++) @(negedge clk);
      check(frames[(base + 5) % 64] == frm(8'hFE), "R4 sixth frame stop from extra bit",
            frames[(base + 5) % 64], frm(8'hFE));
      repeat (20) @(negedge clk);
    end

    check(r5Bad == 0, "R5 byte data edge", r5Bad, 0);
    check(r8Bad == 0, "R8 burst data edge", r8Bad, 0);
    check(r9Bad == 0, "R9 clock low during sync", r9Bad, 0);
    check(rdPulses == pushes, "R10 one pop per word", rdPulses, pushes);
    check(fifoEmpty == 1'b1, "R10 FIFO drained", fifoEmpty, 1);

    summary();
    $finish;
  end

endmodule